// File: doc/BRIEF.md
# Parallel NOR Flash Completion Poller

This block supervises an embedded program or erase operation already running inside a parallel NOR flash array. After a one-cycle start request carrying the status address and the chip base address, it reads the status address twice per step over a simple request/acknowledge memory port. It decides from each pair whether the device is still busy, has finished, or has signalled an internal failure. A finished operation ends with a success result. A failure ends with a reset command written to the chip base, then a failure result. A cycle budget that runs out ends with a timeout result.

The data bus may carry several 8-bit devices side by side, one per byte lane. The toggle comparison and the error test look at every lane. The error flag is always taken from the earlier read of a pair. The later read may already return array contents, because the device has left status mode, and that data must never be mistaken for a failure.

Top module: `nor_toggle_poller`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `rd_req` and `wr_req` are all 0.
- R2: Each poll step issues exactly two reads of the latched status address, one after the other, with at most one transaction outstanding; a request and its address stay asserted until `bus_ack`.
- R3: If bit 6 of any lane differs between the two reads of a pair, the operation is still running and a further pair is read, provided no failure or timeout applies.
- R4: If bit 6 matches in every lane across the pair, the block finishes with result 2'b00 and writes nothing, whatever bit 5 holds.
- R5: The error flag is taken only from bit 5 of the first read of a pair. A second read of 0xFF data after a first read with bits 6 and 5 both 0 is not a failure.
- R6: When a pair toggles and the first read has bit 5 set, the block issues no further read. It writes 0xF0 to every byte lane at the latched base address, then finishes with result 2'b01.
- R7: A failure is raised when bit 5 is set in any single lane of the first read, not only when it is set in all lanes.
- R8: A cycle counter starts at the accepted start and is checked after every read pair. If a pair toggles without error once the limit is reached, the block finishes with result 2'b10 and writes nothing.
- R9: A start request while `busy` is high is ignored; the running job keeps its addresses and produces a single completion.
- R10: Completion is a `done` pulse lasting one cycle with `busy` already low and `result` valid (2'b00, 2'b01 or 2'b10). On failure the pulse follows the acknowledge of the reset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin supervising |
| poll_addr | input | AW | Status address, latched at start |
| base_addr | input | AW | Chip base address for the reset command, latched at start |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 success, 01 device failure, 10 timeout |
| rd_req | output | 1 | Read request, held until acknowledged |
| wr_req | output | 1 | Write request, held until acknowledged |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | 8*LANES | Write data |
| bus_rdata | input | 8*LANES | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transaction complete |

## Verification
The bench feeds a final read of 0xFF after a status read with bit 6 clear. A design that took bit 5 from the later read would report a false failure and write the reset command. It sets bit 5 in only one lane, which a design that required all lanes would miss, and it toggles bit 6 in the upper lane alone, which a design that looked only at lane 0 would treat as finished. It also sets bit 5 with bit 6 steady, which must read as success, and it presents an endless toggle, which must time out without a write. A start arriving mid-job must neither move the poll address nor add a completion.

// File: rtl/tgp_pkg.sv
// Shared types and constants for the toggle-bit poller.
// Assumes byte-wide devices packed side by side on the data bus.
package tgp_pkg;

    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_FAIL    = 2'b01,
        RES_TIMEOUT = 2'b10
    } tgp_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_SECOND,
        ST_EVAL,
        ST_RESET_WR
    } tgp_state_e;

    localparam int          LANE_W     = 8;
    localparam int          TOGGLE_POS = 6;
    localparam int          ERROR_POS  = 5;
    localparam logic [7:0]  RESET_CMD  = 8'hF0;

endpackage

// File: rtl/tgp_lane_eval.sv
// Per-lane status evaluation of one read pair.
// toggling: bit 6 differs in at least one lane between the two reads.
// dev_error: bit 5 of the FIRST read is set in at least one lane.
// Assumes both words are stable while the result is used.
module tgp_lane_eval
    import tgp_pkg::*;
#(
    parameter int LANES = 2,
    localparam int DW   = LANES * LANE_W
) (
    input  logic [DW-1:0] first_word,
    input  logic [DW-1:0] second_word,
    output logic          toggling,
    output logic          dev_error
);

    logic [LANES-1:0] lane_toggle;
    logic [LANES-1:0] lane_err;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // compare the toggle bit of this lane across the pair
        assign lane_toggle[g] = first_word[g*LANE_W + TOGGLE_POS]
                              ^ second_word[g*LANE_W + TOGGLE_POS];
        // error bit comes from the earlier read only
        assign lane_err[g]    = first_word[g*LANE_W + ERROR_POS];
    end

    // any-lane reduction for both flags
    always_comb begin
        toggling  = |lane_toggle;
        dev_error = |lane_err;
    end

endmodule

// File: rtl/tgp_capture.sv
// Holds the two read words of the current poll pair.
// Assumes the strobes are one-cycle and never overlap.
module tgp_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_first,
    input  logic          cap_second,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] first_q,
    output logic [DW-1:0] second_q
);

    // latch each read of the pair as it is acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
        end else begin
            if (cap_first)  first_q  <= rdata;
            if (cap_second) second_q <= rdata;
        end
    end

endmodule

// File: rtl/tgp_timeout.sv
// Saturating cycle counter for the overall polling budget.
// Cleared when a job is accepted, counts while the job runs.
// expired is high once LIMIT cycles have elapsed.
module tgp_timeout #(
    parameter int LIMIT = 100000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

    logic [CW-1:0] count_q;

    // count elapsed cycles, holding at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
        end else if (run && (count_q != LIMIT_V)) begin
            count_q <= count_q + 1'b1;
        end
    end

    // flag the end of the budget
    always_comb expired = (count_q >= LIMIT_V);

endmodule

// File: rtl/nor_toggle_poller.sv
// Supervises an embedded program/erase in a parallel NOR flash by
// reading a status address in pairs and comparing the toggle bit.
// Writes the reset command to the base address on a device failure.
// Assumes a request/acknowledge bus with one transaction in flight;
// requests stay high until bus_ack, and rdata is valid with bus_ack.
module nor_toggle_poller
    import tgp_pkg::*;
#(
    parameter int AW          = 16,
    parameter int LANES       = 2,
    parameter int TIMEOUT_CYC = 100000,
    localparam int DW         = LANES * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] poll_addr,
    input  logic [AW-1:0] base_addr,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result,
    output logic          rd_req,
    output logic          wr_req,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack
);

    tgp_state_e    state_q, state_d;
    logic [AW-1:0] poll_q;
    logic [AW-1:0] base_q;
    logic          done_q;
    tgp_result_e   result_q;

    logic          accept;
    logic          cap_first, cap_second;
    logic [DW-1:0] first_q, second_q;
    logic          toggling, dev_error, expired;
    logic          finish;
    tgp_result_e   finish_res;

    // a new job is taken only when idle
    always_comb accept = start && (state_q == ST_IDLE);

    // capture strobes for each read of the pair
    always_comb begin
        cap_first  = (state_q == ST_RD_FIRST)  && bus_ack;
        cap_second = (state_q == ST_RD_SECOND) && bus_ack;
    end

    tgp_capture #(.DW(DW)) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_first (cap_first),
        .cap_second(cap_second),
        .rdata     (bus_rdata),
        .first_q   (first_q),
        .second_q  (second_q)
    );

    tgp_lane_eval #(.LANES(LANES)) eval_i (
        .first_word (first_q),
        .second_word(second_q),
        .toggling   (toggling),
        .dev_error  (dev_error)
    );

    tgp_timeout #(.LIMIT(TIMEOUT_CYC)) tmo_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .run    (state_q != ST_IDLE),
        .expired(expired)
    );

    // next-state and completion decision
    always_comb begin
        state_d    = state_q;
        finish     = 1'b0;
        finish_res = RES_OK;
        unique case (state_q)
            ST_IDLE:      if (accept)  state_d = ST_RD_FIRST;
            ST_RD_FIRST:  if (bus_ack) state_d = ST_RD_SECOND;
            ST_RD_SECOND: if (bus_ack) state_d = ST_EVAL;
            ST_EVAL: begin
                if (!toggling) begin
                    state_d    = ST_IDLE;
                    finish     = 1'b1;
                    finish_res = RES_OK;
                end else if (dev_error) begin
                    state_d    = ST_RESET_WR;
                end else if (expired) begin
                    state_d    = ST_IDLE;
                    finish     = 1'b1;
                    finish_res = RES_TIMEOUT;
                end else begin
                    state_d    = ST_RD_FIRST;
                end
            end
            ST_RESET_WR: begin
                if (bus_ack) begin
                    state_d    = ST_IDLE;
                    finish     = 1'b1;
                    finish_res = RES_FAIL;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // latch addresses of an accepted job
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_q <= '0;
            base_q <= '0;
        end else if (accept) begin
            poll_q <= poll_addr;
            base_q <= base_addr;
        end
    end

    // one-cycle completion pulse and held result code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= RES_OK;
        end else begin
            done_q <= finish;
            if (finish) result_q <= finish_res;
        end
    end

    // bus side drive, decoded from state
    always_comb begin
        rd_req    = (state_q == ST_RD_FIRST) || (state_q == ST_RD_SECOND);
        wr_req    = (state_q == ST_RESET_WR);
        bus_addr  = wr_req ? base_q : poll_q;
        bus_wdata = {LANES{RESET_CMD}};
    end

    // status outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = done_q;
        result = result_q;
    end

endmodule

// File: rtl/tgp_checker.sv
// Protocol and completion properties of nor_toggle_poller,
// attached through bind. Observes ports plus the latched poll address.
module tgp_checker #(
    parameter int AW    = 16,
    parameter int LANES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic [1:0]           result,
    input logic                 rd_req,
    input logic                 wr_req,
    input logic [AW-1:0]        bus_addr,
    input logic [8*LANES-1:0]   bus_wdata,
    input logic                 bus_ack,
    input logic [AW-1:0]        poll_q
);

    p_req_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !bus_ack) |=> (rd_req && $stable(bus_addr)));

    p_rd_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (bus_addr == poll_q));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(poll_q));

    p_wdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (bus_wdata == {LANES{8'hF0}}));

    p_fail_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'b01) |-> $past(wr_req && bus_ack));

    p_timeout_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'b10) |-> !$past(wr_req));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'b11));

endmodule

bind nor_toggle_poller tgp_checker #(.AW(AW), .LANES(LANES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .poll_q   (poll_q)
);

// File: tb/nor_toggle_poller_tb_top.sv
// Self-checking bench: vector table walk, then directed cases.
module nor_toggle_poller_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int LANES      = 2;
    localparam int DW         = 8 * LANES;
    localparam int TMO        = 60;
    localparam int NVEC       = 9;

    // read scripts (wrapped), script length, expected result, reads, writes
    localparam logic [15:0] RD_TAB [NVEC][4] = '{
        '{16'h1234, 16'h1234, 16'h0000, 16'h0000},  // R4 immediate finish
        '{16'h4040, 16'h0000, 16'hFFFF, 16'hFFFF},  // R3 toggle then finish
        '{16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF},  // R5 array data on 2nd read
        '{16'h6060, 16'h0000, 16'h0000, 16'h0000},  // R6 failure both lanes
        '{16'h0020, 16'h0040, 16'h0000, 16'h0000},  // R7 failure one lane
        '{16'h4040, 16'h2020, 16'h5555, 16'h5555},  // R5 bit5 only in 2nd read
        '{16'h2020, 16'h2020, 16'h0000, 16'h0000},  // R4 bit5 but steady
        '{16'h4000, 16'h0000, 16'h0101, 16'h0101},  // R3 upper lane toggles
        '{16'h4040, 16'h0000, 16'h4040, 16'h0000}   // R8 endless toggle
    };
    localparam int          SCR_N [NVEC] = '{2, 4, 4, 2, 2, 4, 2, 4, 4};
    localparam logic [1:0]  EXP_R [NVEC] = '{2'b00, 2'b00, 2'b00, 2'b01, 2'b01,
                                             2'b00, 2'b00, 2'b00, 2'b10};
    localparam int          EXP_RD[NVEC] = '{2, 4, 4, 2, 2, 4, 2, 4, -1};
    localparam int          EXP_WR[NVEC] = '{0, 0, 0, 1, 1, 0, 0, 0, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic [AW-1:0] base_addr = '0;
    logic          busy, done, rd_req, wr_req;
    logic [1:0]    result;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    // responder state
    logic [15:0] scr [4];
    int          scr_n = 1;
    int          rd_cnt = 0, wr_cnt = 0, addr_bad = 0, done_cnt = 0;
    logic [15:0] exp_poll = '0;
    logic [15:0] wr_addr_l = '0, wr_data_l = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_toggle_poller #(.AW(AW), .LANES(LANES), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .poll_addr(poll_addr), .base_addr(base_addr),
        .busy(busy), .done(done), .result(result),
        .rd_req(rd_req), .wr_req(wr_req), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // bus model: acknowledge each request after one cycle, then drop ack
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (rd_req) begin
            if (bus_addr !== exp_poll) addr_bad++;
            bus_rdata = scr[rd_cnt % scr_n];
            rd_cnt++;
            bus_ack = 1'b1;
        end else if (wr_req) begin
            wr_addr_l = bus_addr;
            wr_data_l = bus_wdata;
            wr_cnt++;
            bus_ack = 1'b1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // start a job and wait for completion; checks pulse shape (R10)
    task automatic run_job(input logic [15:0] pa, input logic [15:0] ba,
                           input bool_inject, output logic [1:0] res);
        bit got = 0;
        rd_cnt = 0; wr_cnt = 0; addr_bad = 0; done_cnt = 0;
        exp_poll = pa;
        poll_addr = pa; base_addr = ba; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        res = 2'b11;
        for (int i = 0; i < 3000; i++) begin
            if (i == 3 && bool_inject) begin
                // R9: second start while busy, different addresses
                check("R9 busy before extra start", 32'(busy), 32'd1);
                poll_addr = 16'hBEEF; base_addr = 16'hDEAD; start = 1'b1;
            end
            if (i == 4) start = 1'b0;
            if (done) begin
                got = 1;
                res = result;
                check("R10 busy low at done", 32'(busy), 32'd0);
                @(negedge clk);
                check("R10 done one cycle", 32'(done), 32'd0);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R10 completion seen (watchdog)", 32'(got), 32'd1);
    endtask

    logic [1:0] res;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 rd_req", 32'(rd_req), 0);
        check("R1 wr_req", 32'(wr_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < 4; k++) scr[k] = RD_TAB[v][k];
            scr_n = SCR_N[v];
            run_job(16'h0100 + 16'(v), 16'hA000 + 16'(v), 1'b0, res);
            check($sformatf("R3/R4/R5/R6/R7/R8 result vec %0d", v), 32'(res), 32'(EXP_R[v]));
            if (EXP_RD[v] >= 0)
                check($sformatf("R2/R6 read count vec %0d", v), 32'(rd_cnt), 32'(EXP_RD[v]));
            else
                check($sformatf("R8 kept polling vec %0d", v), 32'(rd_cnt > 4), 32'd1);
            check($sformatf("R6/R8 write count vec %0d", v), 32'(wr_cnt), 32'(EXP_WR[v]));
            check($sformatf("R2 poll address vec %0d", v), 32'(addr_bad), 0);
            if (EXP_WR[v] == 1) begin
                check($sformatf("R6 write addr vec %0d", v), 32'(wr_addr_l), 32'(16'hA000 + 16'(v)));
                check($sformatf("R6 write data vec %0d", v), 32'(wr_data_l), 32'h0000F0F0);
            end
            repeat (2) @(negedge clk);
        end

        // R9: extra start during a long job is ignored
        for (int k = 0; k < 4; k++) scr[k] = RD_TAB[8][k];
        scr_n = 4;
        run_job(16'h0777, 16'h0888, 1'b1, res);
        check("R9 result unaffected", 32'(res), 32'h2);
        check("R9 poll address kept", 32'(addr_bad), 0);
        repeat (5) @(negedge clk);
        check("R9 single completion", 32'(done_cnt), 1);
        check("R9 idle afterwards", 32'(busy), 0);

        // R1: reset mid-job returns to idle
        scr[0] = 16'h4040; scr[1] = 16'h0000; scr_n = 2;
        poll_addr = 16'h0042; exp_poll = 16'h0042; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy), 0);
        check("R1 rd_req after reset", 32'(rd_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule